// File: doc/BRIEF.md
# Latched Multi-Record Serial Readout Port

This block is the device side of a read-only serial port. A set of internal record words, eight of 32 bits by default, is copied into a bank of holding registers on request. A host then clocks the copy out one bit at a time on a single data line. The host drives four wires: an active-high sync line, an active-low chip select, a serial clock, and the data line it reads. Every host wire is synchronized into the local measurement clock domain before it is used.

The sync line has two roles, chosen by chip select. While chip select is idle, a sync pulse that lasts at least `MIN_SYNC` measurement clock cycles takes a snapshot of all live records. A shorter pulse is ignored. While chip select is active, sync only returns the read position to record 0, bit 0. This lets the host start a read cleanly or re-align a read in progress.

Each rising serial clock edge moves the read position on by one bit. Within a record the most significant bit comes first, and records are sent in index order. Releasing chip select ends the read at once.

Top module: `snap_serial_reader`

## Requirements
- R1: After reset, `sdo_o` is 0, every held record is zero, and the read position is record 0, bit 0.
- R2: With chip select idle, a sync pulse that stays high for at least `MIN_SYNC` synchronized clock cycles (2 by default) copies all live records into the holding registers when the pulse falls.
- R3: A sync pulse of fewer than `MIN_SYNC` synchronized cycles, given while chip select is idle, leaves the held records unchanged.
- R4: While chip select is active and sync is low, `sdo_o` presents bit (`REC_W`-1-b) of held record r at read position (r, b). Each rising serial clock edge advances b, and after the last bit of a record the position moves to bit 0 of record r+1.
- R5: Once the last bit of the last record has been passed, `sdo_o` stays 0 until chip select is released.
- R6: A sync pulse of any length while chip select is active returns the position to record 0, bit 0, and does not change the held records.
- R7: If a qualifying sync pulse is still high when chip select becomes active, the snapshot is taken at that moment and taken only once. Shifting then starts from record 0, bit 0 after sync falls.
- R8: Releasing chip select aborts the read. The next read starts at record 0, bit 0 and still sees the same held records.
- R9: The held records do not change while no snapshot is taken, even when the live record inputs change.
- R10: While chip select is idle, `sdo_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Measurement clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_i | input | 1 | Sync line, active high, asynchronous |
| cs_n_i | input | 1 | Chip select, active low, asynchronous |
| sclk_i | input | 1 | Serial clock from the host, asynchronous, idles low |
| rec_i | input | NREC*REC_W | Live record words, record k in bits [k*REC_W +: REC_W] |
| sdo_o | output | 1 | Serial data to the host |

## Verification
The hardest case to reach is a sync pulse that carries over from the latching phase into the start of a read. To get there, the bench holds sync high past the width threshold, lowers chip select while sync is still high, and lowers sync only a few cycles later. It changes the live records after the snapshot and then reads every record, so a missed snapshot or a second one would show up as wrong words. The width boundary is also probed, with pulses of exactly one and exactly two synchronized cycles. Sync pulses sent in the middle of a read, and a read aborted partway through a record, show that the position returns to the start and that the held records stay as they were.

// File: rtl/snapread_pkg.sv
package snapread_pkg;
   // Index width that never collapses to zero bits.
   function automatic int idx_width(input int count);
      return (count <= 2) ? 1 : $clog2(count);
   endfunction

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/sr_sync.sv
module sr_sync #(
   parameter int STAGES = 2,
   parameter int W      = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] chain [STAGES];

   if (STAGES < 2) begin : g_bad_stages
      $error("sr_sync: STAGES must be at least 2");
   end

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            chain[s] <= '0;
         else if (s == 0)
            chain[s] <= d;
         else
            chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/sr_latch_ctl.sv
module sr_latch_ctl #(
   parameter int MIN_SYNC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sync_s,
   input  logic sync_fall,
   input  logic cs_act,
   input  logic cs_rise,
   output logic load
);
   localparam int CW = $clog2(MIN_SYNC + 1);
   localparam logic [CW-1:0] LIMIT = CW'(MIN_SYNC);

   logic [CW-1:0] width_cnt;
   logic          armed;

   if (MIN_SYNC < 1) begin : g_bad_min
      $error("sr_latch_ctl: MIN_SYNC must be at least 1");
   end

   // Saturating width counter; counts only while idle and sync high.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         width_cnt <= '0;
      else if (!sync_s || cs_act)
         width_cnt <= '0;
      else if (width_cnt < LIMIT)
         width_cnt <= width_cnt + 1'b1;
   end

   assign armed = (width_cnt >= LIMIT);
   assign load  = armed && ((sync_fall && !cs_act) || (cs_rise && sync_s));
endmodule

// File: rtl/sr_store.sv
module sr_store #(
   parameter int NREC  = 8,
   parameter int REC_W = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  load,
   input  logic [NREC*REC_W-1:0] live_i,
   output logic [NREC*REC_W-1:0] held_o
);
   for (genvar k = 0; k < NREC; k++) begin : g_rec
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            held_o[k*REC_W +: REC_W] <= '0;
         else if (load)
            held_o[k*REC_W +: REC_W] <= live_i[k*REC_W +: REC_W];
      end
   end

   p_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(held_o))
      else $error("held records changed without a snapshot");
endmodule

// File: rtl/sr_shifter.sv
module sr_shifter
   import snapread_pkg::*;
#(
   parameter int NREC  = 8,
   parameter int REC_W = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cs_act,
   input  logic                  sync_s,
   input  logic                  step,
   input  logic [NREC*REC_W-1:0] held_i,
   output logic                  sdo
);
   localparam int BIT_W = idx_width(REC_W);
   localparam int IDX_W = idx_width(NREC);
   localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(REC_W - 1);
   localparam logic [IDX_W-1:0] LAST_REC = IDX_W'(NREC - 1);

   logic [BIT_W-1:0] bit_idx;
   logic [IDX_W-1:0] rec_idx;
   logic             done;
   logic [REC_W-1:0] words [NREC];
   logic [REC_W-1:0] cur_word;
   logic [BIT_W-1:0] pick;

   for (genvar k = 0; k < NREC; k++) begin : g_word
      assign words[k] = held_i[k*REC_W +: REC_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_idx <= '0;
         rec_idx <= '0;
         done    <= 1'b0;
      end else if (!cs_act || sync_s) begin
         bit_idx <= '0;
         rec_idx <= '0;
         done    <= 1'b0;
      end else if (step && !done) begin
         if (bit_idx == LAST_BIT) begin
            bit_idx <= '0;
            if (rec_idx == LAST_REC)
               done <= 1'b1;
            else
               rec_idx <= rec_idx + 1'b1;
         end else begin
            bit_idx <= bit_idx + 1'b1;
         end
      end
   end

   assign cur_word = words[rec_idx];
   assign pick     = LAST_BIT - bit_idx;
   assign sdo      = cs_act && !done && cur_word[pick];

   p_advance_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_act && !sync_s && step && !done && bit_idx != LAST_BIT)
      |=> bit_idx == BIT_W'($past(bit_idx) + 1'b1))
      else $error("bit position did not advance");

   p_done_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (done && cs_act && !sync_s) |=> done)
      else $error("end-of-read state left while selected");

   p_realign_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_act && sync_s) |=> (bit_idx == '0 && rec_idx == '0 && !done))
      else $error("sync did not return position to start");

   p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_act |=> (bit_idx == '0 && rec_idx == '0 && !done))
      else $error("position not cleared while deselected");
endmodule

// File: rtl/snap_serial_reader.sv
module snap_serial_reader
   import snapread_pkg::*;
#(
   parameter int NREC        = 8,
   parameter int REC_W       = 32,
   parameter int MIN_SYNC    = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  sync_i,
   input  logic                  cs_n_i,
   input  logic                  sclk_i,
   input  logic [NREC*REC_W-1:0] rec_i,
   output logic                  sdo_o
);
   if (!is_pow2(NREC) || NREC < 2) begin : g_bad_nrec
      $error("snap_serial_reader: NREC must be a power of two, at least 2");
   end
   if (!is_pow2(REC_W) || REC_W < 2) begin : g_bad_recw
      $error("snap_serial_reader: REC_W must be a power of two, at least 2");
   end

   logic       sync_s, cs_act, sclk_s;
   logic       sync_p, cs_p, sclk_p;
   logic       sync_fall, cs_rise, step, load;
   logic [NREC*REC_W-1:0] held;

   sr_sync #(.STAGES(SYNC_STAGES), .W(3)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({sync_i, ~cs_n_i, sclk_i}),
      .q     ({sync_s, cs_act, sclk_s})
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_p <= 1'b0;
         cs_p   <= 1'b0;
         sclk_p <= 1'b0;
      end else begin
         sync_p <= sync_s;
         cs_p   <= cs_act;
         sclk_p <= sclk_s;
      end
   end

   assign sync_fall = sync_p && !sync_s;
   assign cs_rise   = cs_act && !cs_p;
   assign step      = sclk_s && !sclk_p;

   sr_latch_ctl #(.MIN_SYNC(MIN_SYNC)) u_latch (
      .clk       (clk),
      .rst_n     (rst_n),
      .sync_s    (sync_s),
      .sync_fall (sync_fall),
      .cs_act    (cs_act),
      .cs_rise   (cs_rise),
      .load      (load)
   );

   sr_store #(.NREC(NREC), .REC_W(REC_W)) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (load),
      .live_i (rec_i),
      .held_o (held)
   );

   sr_shifter #(.NREC(NREC), .REC_W(REC_W)) u_shift (
      .clk    (clk),
      .rst_n  (rst_n),
      .cs_act (cs_act),
      .sync_s (sync_s),
      .step   (step),
      .held_i (held),
      .sdo    (sdo_o)
   );

   p_load_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> !load)
      else $error("snapshot taken on two consecutive cycles");
endmodule

// File: tb/snap_serial_reader_test.sv
module snap_serial_reader_test;
   localparam int NREC  = 8;
   localparam int REC_W = 32;
   localparam int TOTAL = NREC * REC_W;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sync_i = 1'b0;
   logic cs_n_i = 1'b1;
   logic sclk_i = 1'b0;
   logic [NREC*REC_W-1:0] rec_i = '0;
   logic sdo_o;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   snap_serial_reader #(.NREC(NREC), .REC_W(REC_W)) uut (
      .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .cs_n_i(cs_n_i),
      .sclk_i(sclk_i), .rec_i(rec_i), .sdo_o(sdo_o)
   );

   // ---------------- behavioural cycle model ----------------
   bit  dq_sync[$], dq_cs[$], dq_sclk[$];
   bit  m_sync_prev, m_cs_prev, m_sclk_prev;
   int  m_width, m_pos;
   logic [REC_W-1:0] m_snap [NREC];
   bit  model_ok = 1'b0;

   function automatic bit m_expect();
      bit cs_now;
      cs_now = dq_cs[0];
      if (!cs_now || m_pos >= TOTAL) return 1'b0;
      return m_snap[m_pos / REC_W][REC_W - 1 - (m_pos % REC_W)];
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dq_sync = '{0, 0}; dq_cs = '{0, 0}; dq_sclk = '{0, 0};
         m_sync_prev = 0; m_cs_prev = 0; m_sclk_prev = 0;
         m_width = 0; m_pos = 0;
         foreach (m_snap[k]) m_snap[k] = '0;
      end else begin
         bit s, c, k;
         s = dq_sync[0]; c = dq_cs[0]; k = dq_sclk[0];
         if (m_width >= 2 && ((m_sync_prev && !s && !c) || (c && !m_cs_prev && s)))
            for (int r = 0; r < NREC; r++) m_snap[r] = rec_i[r*REC_W +: REC_W];
         if (!s || c) m_width = 0;
         else if (m_width < 2) m_width++;
         if (!c || s) m_pos = 0;
         else if (k && !m_sclk_prev && m_pos < TOTAL) m_pos++;
         m_sync_prev = s; m_cs_prev = c; m_sclk_prev = k;
         void'(dq_sync.pop_front()); dq_sync.push_back(sync_i);
         void'(dq_cs.pop_front());   dq_cs.push_back(!cs_n_i);
         void'(dq_sclk.pop_front()); dq_sclk.push_back(sclk_i);
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (model_ok && rst_n)
         chk(sdo_o == m_expect(), "R4 cycle model", 32'(sdo_o), 32'(m_expect()));
   end

   // ---------------- stimulus helpers ----------------
   logic [REC_W-1:0] exp_rec [NREC];

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [REC_W-1:0] pat(input int seed, input int r);
      return (32'h9E3779B9 * (seed + 1)) ^ (32'h01010101 * (r + 3)) ^ (32'(r) << 28);
   endfunction

   task automatic set_live(input int seed);
      for (int r = 0; r < NREC; r++) rec_i[r*REC_W +: REC_W] = pat(seed, r);
   endtask

   task automatic remember(input int seed);
      for (int r = 0; r < NREC; r++) exp_rec[r] = pat(seed, r);
   endtask

   task automatic sync_pulse(input int w);
      sync_i = 1'b1; tick(w); sync_i = 1'b0; tick(5);
   endtask

   task automatic sel(input bit on);
      cs_n_i = !on; tick(5);
   endtask

   task automatic read_bits(input int n, output logic [REC_W-1:0] w);
      w = '0;
      for (int b = 0; b < n; b++) begin
         tick(4);
         w = {w[REC_W-2:0], sdo_o};
         sclk_i = 1'b1; tick(4); sclk_i = 1'b0;
      end
   endtask

   // ---------------- directed sequence ----------------
   initial begin
      logic [REC_W-1:0] w;
      tick(3);
      chk(sdo_o == 1'b0, "R1 reset output", 32'(sdo_o), 0);
      rst_n = 1'b1; model_ok = 1'b1;
      tick(3);

      // R1: held records start at zero
      sel(1); read_bits(REC_W, w);
      chk(w == '0, "R1 held zero", w, 0);
      sel(0);

      // R2 + R9: snapshot, then live inputs change
      set_live(1); remember(1);
      sync_pulse(5);
      set_live(2);
      sel(1);
      for (int r = 0; r < NREC; r++) begin
         read_bits(REC_W, w);
         chk(w == exp_rec[r], "R4 record order / R9 frozen", w, exp_rec[r]);
      end
      read_bits(REC_W, w);
      chk(w == '0, "R5 hold zero after end", w, 0);
      sel(0);
      tick(2);
      chk(sdo_o == 1'b0, "R10 idle output", 32'(sdo_o), 0);

      // R3: one-cycle pulse must not latch
      set_live(3);
      sync_pulse(1);
      sel(1); read_bits(REC_W, w);
      chk(w == exp_rec[0], "R3 short pulse ignored", w, exp_rec[0]);
      sel(0);

      // R2 boundary: exactly two cycles latches
      remember(3);
      sync_pulse(2);
      sel(1); read_bits(REC_W, w);
      chk(w == exp_rec[0], "R2 two-cycle pulse latches", w, exp_rec[0]);
      sel(0);

      // R8: abort mid-record, restart at record 0 bit 0
      sel(1); read_bits(REC_W, w); read_bits(7, w);
      sel(0); sel(1);
      read_bits(REC_W, w);
      chk(w == exp_rec[0], "R8 restart word0", w, exp_rec[0]);
      read_bits(REC_W, w);
      chk(w == exp_rec[1], "R8 restart word1", w, exp_rec[1]);
      sel(0);

      // R6: sync while selected realigns and never latches
      set_live(4);
      sel(1); read_bits(10, w);
      sync_pulse(1);
      read_bits(REC_W, w);
      chk(w == exp_rec[0], "R6 short realign", w, exp_rec[0]);
      read_bits(REC_W - 3, w);
      sync_pulse(6);
      read_bits(REC_W, w);
      chk(w == exp_rec[0], "R6 long pulse no latch", w, exp_rec[0]);
      sel(0);

      // R7: pulse carried from latching into select
      set_live(5); remember(5);
      sync_i = 1'b1; tick(5);
      cs_n_i = 1'b0; tick(4);
      sync_i = 1'b0; tick(5);
      set_live(6);
      for (int r = 0; r < NREC; r++) begin
         read_bits(REC_W, w);
         chk(w == exp_rec[r], "R7 carried pulse", w, exp_rec[r]);
      end
      sel(0);
      tick(2);
      chk(sdo_o == 1'b0, "R10 idle after read", 32'(sdo_o), 0);

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end
endmodule